// File: doc/BRIEF.md
# Shift, Extend and Alignment Unit

This unit is a helper stage for a 32-bit load/store datapath. It merges three jobs into one registered stage: a barrel shifter with logical-left, logical-right and arithmetic-right modes; widening of 16-bit immediates and of loaded bytes or halfwords with sign or zero fill; and byte-lane steering for a big-endian, byte-addressable memory on both the load and the store side. Only one of these three jobs is active in a cycle, and the operation code selects which.

The caller presents an operation code, a data operand, a shift amount and the low address bits together with a valid strobe. One clock later the unit shows the result, a per-lane byte-enable vector and an alignment-error flag. For a load the operand is the word read from memory. For a store it is the register value to be written.

Top module: `sxa_unit`

## Requirements
- R1: Op code 0x0 shifts the operand left by `shamt` (0..31) and fills the vacated low bits with zeros.
- R2: Op code 0x1 shifts the operand right by `shamt` and fills the vacated high bits with zeros.
- R3: Op code 0x2 shifts the operand right by `shamt` and fills the vacated high bits with copies of operand bit 31.
- R4: Op code 0x3 sign-extends operand bits 15:0 to 32 bits. Op code 0x4 zero-extends them. Neither sets a byte enable.
- R5: Op codes 0x5 (signed) and 0x6 (unsigned) load a byte. Address offset k selects operand bits (31-8k):(24-8k), so offset 0 is bits 31:24. The byte is moved to bits 7:0 and then sign-extended or zero-extended.
- R6: Op codes 0x7 (signed) and 0x8 (unsigned) load a halfword. Offset 0 selects bits 31:16 and offset 2 selects bits 15:0. The halfword is moved to bits 15:0 and then extended.
- R7: Op code 0x9 loads a word and returns the operand unchanged.
- R8: Op code 0xA (byte store) copies operand bits 7:0 into all four lanes. Op code 0xB (halfword store) copies bits 15:0 into both halves. Op code 0xC (word store) passes the operand unchanged.
- R9: `byte_en` bit i covers result bits 8i+7:8i. A byte access at offset k sets only bit 3-k. A halfword access sets 4'b1100 at offset 0 and 4'b0011 at offset 2. A word access sets 4'b1111. This holds for loads and stores alike.
- R10: A halfword access at an odd offset, or a word load or store at a nonzero offset, sets `align_err`, forces `byte_en` to 0 and forces `result` to 0.
- R11: Outputs update exactly one clock after an edge where `in_valid` is high, and `out_valid` is high for that one cycle. When `in_valid` is low, `result`, `byte_en` and `align_err` keep their values and `out_valid` is low.
- R12: Shift and immediate ops, and the unused codes 0xD to 0xF, never set `align_err` or `byte_en`. The unused codes give a result of 0.
- R13: While `rst_n` is low, `out_valid`, `result`, `byte_en` and `align_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are valid and are captured on this edge |
| op | input | 4 | Operation code |
| operand | input | 32 | Data to shift, extend, align or store |
| shamt | input | 5 | Shift amount |
| addr_lo | input | 2 | Byte offset within the word |
| out_valid | output | 1 | Registered result is fresh |
| result | output | 32 | Registered result |
| byte_en | output | 4 | Registered lane enables, bit 3 covers bits 31:24 |
| align_err | output | 1 | Registered misalignment flag |

## Verification
Lane steering and misalignment detection act in the same cycle on every halfword and word access. Each such access must either produce a lane pattern or a suppressed, flagged result, and never both. The bench drives halfword and word loads and stores at every one of the four offsets, both directed and randomly mixed with shifts. For each one it compares data, enables and the error flag against a model written from the requirements. A back-to-back stream of valid operations with gaps of idle cycles also checks that an idle cycle leaves the previous misaligned or aligned outcome untouched.

// File: rtl/sxa_pkg.sv
package sxa_pkg;

   typedef enum logic [3:0] {
      SXA_SLL   = 4'h0,
      SXA_SRL   = 4'h1,
      SXA_SRA   = 4'h2,
      SXA_IMM_S = 4'h3,
      SXA_IMM_Z = 4'h4,
      SXA_LD_B  = 4'h5,
      SXA_LD_BU = 4'h6,
      SXA_LD_H  = 4'h7,
      SXA_LD_HU = 4'h8,
      SXA_LD_W  = 4'h9,
      SXA_ST_B  = 4'hA,
      SXA_ST_H  = 4'hB,
      SXA_ST_W  = 4'hC
   } sxa_op_e;

   // access width selector shared by the extract and steer stages
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_IMM  = 2'd3
   } sxa_size_e;

endpackage

// File: rtl/sxa_shifter.sv
module sxa_shifter #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = $clog2(DATA_W),
   parameter int IMPL    = 0          // 0: staged log shifter, 1: operator form
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHAMT_W-1:0] amt,
   input  logic               to_left,
   input  logic               arith,
   output logic [DATA_W-1:0]  dout
);

   generate
      if (IMPL == 0) begin : g_staged
         logic [DATA_W-1:0] fill;
         assign fill = {DATA_W{arith & din[DATA_W-1]}};
         always_comb begin
            logic [DATA_W-1:0] v;
            v = din;
            for (int s = 0; s < SHAMT_W; s++) begin
               if (amt[s]) begin
                  if (to_left)
                     v = v << (1 << s);
                  else
                     v = (v >> (1 << s)) | (fill << (DATA_W - (1 << s)));
               end
            end
            dout = v;
         end
      end else begin : g_operator
         always_comb begin
            if (to_left)
               dout = din << amt;
            else if (arith)
               dout = DATA_W'($signed(din) >>> amt);
            else
               dout = din >> amt;
         end
      end
   endgenerate

endmodule

// File: rtl/sxa_extract.sv
module sxa_extract
   import sxa_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   localparam int LANES  = DATA_W / 8,
   localparam int AOFF_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [AOFF_W-1:0] aoff,
   input  sxa_size_e         size,
   input  logic              sign,
   output logic [DATA_W-1:0] dout
);

   // big-endian: offset 0 is the most significant lane
   logic [AOFF_W-1:0] b_inv;
   logic [AOFF_W-2:0] h_inv;
   logic [DATA_W-1:0] b_sh, h_sh;
   logic [7:0]        b_lane;
   logic [15:0]       h_lane;

   assign b_inv  = ~aoff;
   assign h_inv  = ~aoff[AOFF_W-1:1];
   assign b_sh   = din >> {b_inv, 3'b000};
   assign h_sh   = din >> {h_inv, 4'b0000};
   assign b_lane = b_sh[7:0];
   assign h_lane = h_sh[15:0];

   always_comb begin
      unique case (size)
         SZ_BYTE: dout = {{(DATA_W-8){sign & b_lane[7]}}, b_lane};
         SZ_HALF: dout = {{(DATA_W-16){sign & h_lane[15]}}, h_lane};
         SZ_IMM:  dout = {{(DATA_W-IMM_W){sign & din[IMM_W-1]}}, din[IMM_W-1:0]};
         default: dout = din;
      endcase
   end

endmodule

// File: rtl/sxa_steer.sv
module sxa_steer
   import sxa_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int AOFF_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [AOFF_W-1:0] aoff,
   input  sxa_size_e         size,
   input  logic              is_mem,
   output logic [DATA_W-1:0] st_data,
   output logic [LANES-1:0]  be,
   output logic              misal
);

   localparam logic [LANES-1:0] ONE_LANE = LANES'(1);
   localparam logic [LANES-1:0] TWO_LANE = LANES'(3);

   logic [AOFF_W-1:0] b_inv;
   logic [AOFF_W-2:0] h_inv;
   logic [LANES-1:0]  be_raw;

   assign b_inv = ~aoff;
   assign h_inv = ~aoff[AOFF_W-1:1];

   always_comb begin
      unique case (size)
         SZ_BYTE: st_data = {LANES{din[7:0]}};
         SZ_HALF: st_data = {(LANES/2){din[15:0]}};
         default: st_data = din;
      endcase
   end

   always_comb begin
      unique case (size)
         SZ_BYTE: begin be_raw = ONE_LANE << b_inv;          misal = 1'b0;     end
         SZ_HALF: begin be_raw = TWO_LANE << {h_inv, 1'b0};  misal = aoff[0];  end
         SZ_WORD: begin be_raw = '1;                         misal = |aoff;    end
         default: begin be_raw = '0;                         misal = 1'b0;     end
      endcase
   end

   assign be = (is_mem && !misal) ? be_raw : '0;

endmodule

// File: rtl/sxa_unit.sv
module sxa_unit
   import sxa_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SHIFT_IMPL = 0,
   localparam int SHAMT_W = $clog2(DATA_W),
   localparam int LANES   = DATA_W / 8,
   localparam int AOFF_W  = $clog2(LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [3:0]         op,
   input  logic [DATA_W-1:0]  operand,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [AOFF_W-1:0]  addr_lo,
   output logic               out_valid,
   output logic [DATA_W-1:0]  result,
   output logic [LANES-1:0]   byte_en,
   output logic               align_err
);

   generate
      if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("sxa_unit: DATA_W must be a power of two of at least 32");
      end
      if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_impl
         $error("sxa_unit: SHIFT_IMPL must be 0 or 1");
      end
   endgenerate

   // ---------------- decode ----------------
   typedef enum logic [1:0] {PATH_SHIFT, PATH_EXT, PATH_STORE, PATH_NONE} path_e;

   path_e     path;
   sxa_size_e size;
   logic      sgn, to_left, arith, is_mem;

   always_comb begin
      path = PATH_NONE; size = SZ_WORD; sgn = 1'b0;
      to_left = 1'b0; arith = 1'b0; is_mem = 1'b0;
      case (op)
         SXA_SLL:   begin path = PATH_SHIFT; to_left = 1'b1; end
         SXA_SRL:   path = PATH_SHIFT;
         SXA_SRA:   begin path = PATH_SHIFT; arith = 1'b1; end
         SXA_IMM_S: begin path = PATH_EXT; size = SZ_IMM; sgn = 1'b1; end
         SXA_IMM_Z: begin path = PATH_EXT; size = SZ_IMM; end
         SXA_LD_B:  begin path = PATH_EXT; size = SZ_BYTE; sgn = 1'b1; is_mem = 1'b1; end
         SXA_LD_BU: begin path = PATH_EXT; size = SZ_BYTE; is_mem = 1'b1; end
         SXA_LD_H:  begin path = PATH_EXT; size = SZ_HALF; sgn = 1'b1; is_mem = 1'b1; end
         SXA_LD_HU: begin path = PATH_EXT; size = SZ_HALF; is_mem = 1'b1; end
         SXA_LD_W:  begin path = PATH_EXT; size = SZ_WORD; is_mem = 1'b1; end
         SXA_ST_B:  begin path = PATH_STORE; size = SZ_BYTE; is_mem = 1'b1; end
         SXA_ST_H:  begin path = PATH_STORE; size = SZ_HALF; is_mem = 1'b1; end
         SXA_ST_W:  begin path = PATH_STORE; size = SZ_WORD; is_mem = 1'b1; end
         default:   path = PATH_NONE;
      endcase
   end

   // ---------------- datapath pieces ----------------
   logic [DATA_W-1:0] shf_d, ext_d, st_d, nxt_res;
   logic [LANES-1:0]  nxt_be;
   logic              nxt_misal;

   sxa_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .IMPL(SHIFT_IMPL)) u_shf (
      .din(operand), .amt(shamt), .to_left(to_left), .arith(arith), .dout(shf_d)
   );

   sxa_extract #(.DATA_W(DATA_W)) u_ext (
      .din(operand), .aoff(addr_lo), .size(size), .sign(sgn), .dout(ext_d)
   );

   sxa_steer #(.DATA_W(DATA_W)) u_steer (
      .din(operand), .aoff(addr_lo), .size(size), .is_mem(is_mem),
      .st_data(st_d), .be(nxt_be), .misal(nxt_misal)
   );

   always_comb begin
      if (nxt_misal && is_mem)
         nxt_res = '0;
      else begin
         unique case (path)
            PATH_SHIFT: nxt_res = shf_d;
            PATH_EXT:   nxt_res = ext_d;
            PATH_STORE: nxt_res = st_d;
            default:    nxt_res = '0;
         endcase
      end
   end

   // ---------------- output register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         byte_en   <= '0;
         align_err <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= nxt_res;
            byte_en   <= nxt_be;
            align_err <= nxt_misal & is_mem;
         end
      end
   end

   // ---------------- assertions ----------------
   // R1
   zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == SXA_SLL && shamt == '0) |=> (result == $past(operand)));

   // R3
   sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == SXA_SRA && operand[DATA_W-1]) |=> result[DATA_W-1]);

   // R9
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(byte_en) == 0 || $countones(byte_en) == 1 ||
       $countones(byte_en) == 2 || $countones(byte_en) == LANES));

   // R10
   misal_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> (byte_en == '0 && result == '0));

   // R11
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(byte_en) && $stable(align_err)));

   // R12
   non_mem_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op <= SXA_IMM_Z || op > SXA_ST_W)) |=> (!align_err && byte_en == '0));

endmodule

// File: tb/sxa_unit_test.sv
module sxa_unit_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [3:0]  op;
   logic [31:0] operand;
   logic [4:0]  shamt;
   logic [1:0]  addr_lo;
   logic        out_valid;
   logic [31:0] result;
   logic [3:0]  byte_en;
   logic        align_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   sxa_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .operand(operand),
      .shamt(shamt), .addr_lo(addr_lo), .out_valid(out_valid), .result(result),
      .byte_en(byte_en), .align_err(align_err)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // reference model written from the requirement list
   function automatic logic [36:0] model(logic [3:0] o, logic [31:0] d, logic [4:0] s, logic [1:0] a);
      logic [31:0] r; logic [3:0] be; logic mis; logic [7:0] b; logic [15:0] h;
      r = 0; be = 0; mis = 0;
      b = (a == 0) ? d[31:24] : (a == 1) ? d[23:16] : (a == 2) ? d[15:8] : d[7:0];
      h = a[1] ? d[15:0] : d[31:16];
      case (o)
         4'h0: r = d << s;
         4'h1: r = d >> s;
         4'h2: r = 32'($signed(d) >>> s);
         4'h3: r = {{16{d[15]}}, d[15:0]};
         4'h4: r = {16'h0, d[15:0]};
         4'h5: begin r = {{24{b[7]}}, b}; be = 4'b1000 >> a; end
         4'h6: begin r = {24'h0, b};      be = 4'b1000 >> a; end
         4'h7: begin r = {{16{h[15]}}, h}; be = a[1] ? 4'b0011 : 4'b1100; mis = a[0]; end
         4'h8: begin r = {16'h0, h};       be = a[1] ? 4'b0011 : 4'b1100; mis = a[0]; end
         4'h9: begin r = d; be = 4'b1111; mis = (a != 0); end
         4'hA: begin r = {4{d[7:0]}}; be = 4'b1000 >> a; end
         4'hB: begin r = {2{d[15:0]}}; be = a[1] ? 4'b0011 : 4'b1100; mis = a[0]; end
         4'hC: begin r = d; be = 4'b1111; mis = (a != 0); end
         default: r = 0;
      endcase
      if (mis) begin r = 0; be = 0; end
      return {mis, be, r};
   endfunction

   function automatic string req_of(logic [3:0] o, logic mis);
      if (mis) return "R10";
      case (o)
         4'h0: return "R1";
         4'h1: return "R2";
         4'h2: return "R3";
         4'h3, 4'h4: return "R4";
         4'h5, 4'h6: return "R5";
         4'h7, 4'h8: return "R6";
         4'h9: return "R7";
         4'hA, 4'hB, 4'hC: return "R8";
         default: return "R12";
      endcase
   endfunction

   task automatic run_op(logic [3:0] o, logic [31:0] d, logic [4:0] s, logic [1:0] a);
      logic [36:0] e; string rq;
      @(negedge clk);
      in_valid = 1'b1; op = o; operand = d; shamt = s; addr_lo = a;
      e  = model(o, d, s, a);
      rq = req_of(o, e[36]);
      @(posedge clk); #1;
      chk(rq, "result", result, e[31:0]);
      chk((o >= 4'h5 && o <= 4'hC) ? "R9" : "R12", "byte_en", {28'h0, byte_en}, {28'h0, e[35:32]});
      chk(rq, "align_err", {31'h0, align_err}, {31'h0, e[36]});
      chk("R11", "out_valid", {31'h0, out_valid}, 32'h1);
   endtask

   task automatic idle_check(logic [3:0] o, logic [31:0] d);
      logic [31:0] r0; logic [3:0] b0; logic a0;
      r0 = result; b0 = byte_en; a0 = align_err;
      @(negedge clk);
      in_valid = 1'b0; op = o; operand = d; shamt = 5'd7; addr_lo = 2'd1;
      @(posedge clk); #1;
      chk("R11", "idle result", result, r0);
      chk("R11", "idle byte_en", {28'h0, byte_en}, {28'h0, b0});
      chk("R11", "idle align_err", {31'h0, align_err}, {31'h0, a0});
      chk("R11", "idle out_valid", {31'h0, out_valid}, 32'h0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17_0C3B));
      rst_n = 1'b0; in_valid = 1'b0; op = 4'h0; operand = 32'h0; shamt = 5'h0; addr_lo = 2'h0;
      repeat (3) @(posedge clk);
      in_valid = 1'b1; operand = 32'hFFFF_FFFF;   // inputs active while in reset
      @(posedge clk); #1;
      chk("R13", "reset out_valid", {31'h0, out_valid}, 32'h0);
      chk("R13", "reset result", result, 32'h0);
      chk("R13", "reset byte_en", {28'h0, byte_en}, 32'h0);
      chk("R13", "reset align_err", {31'h0, align_err}, 32'h0);
      @(negedge clk); in_valid = 1'b0; rst_n = 1'b1;

      // shifts: R1 R2 R3
      run_op(4'h0, 32'hDEAD_BEEF, 5'd0, 2'd3);
      run_op(4'h0, 32'h0000_0001, 5'd31, 2'd0);
      run_op(4'h1, 32'h8000_0000, 5'd31, 2'd2);
      run_op(4'h2, 32'h8000_0000, 5'd31, 2'd1);
      run_op(4'h2, 32'h7000_0000, 5'd4, 2'd0);
      run_op(4'h2, 32'hF0F0_0000, 5'd0, 2'd0);
      // immediates R4
      run_op(4'h3, 32'h1234_8000, 5'd3, 2'd1);
      run_op(4'h4, 32'h1234_8000, 5'd3, 2'd1);
      run_op(4'h3, 32'hFFFF_7FFF, 5'd0, 2'd0);
      // loads R5 R6 R7 at every offset
      for (int a = 0; a < 4; a++) begin
         run_op(4'h5, 32'h81_22_F3_44, 5'd0, 2'(a));
         run_op(4'h6, 32'h81_22_F3_44, 5'd0, 2'(a));
         run_op(4'h7, 32'h8001_F00E, 5'd0, 2'(a));
         run_op(4'h8, 32'h8001_F00E, 5'd0, 2'(a));
         run_op(4'h9, 32'hCAFE_1234, 5'd0, 2'(a));
         run_op(4'hA, 32'h0000_00A5, 5'd0, 2'(a));
         run_op(4'hB, 32'h0000_BEEF, 5'd0, 2'(a));
         run_op(4'hC, 32'h0BAD_F00D, 5'd0, 2'(a));
      end
      // unused codes R12
      run_op(4'hD, 32'hFFFF_FFFF, 5'd5, 2'd1);
      run_op(4'hF, 32'h1234_5678, 5'd5, 2'd0);
      // idle hold after misaligned and after aligned results R11
      run_op(4'hB, 32'h0000_1111, 5'd0, 2'd3);
      idle_check(4'hA, 32'h0000_0077);
      run_op(4'hA, 32'h0000_0077, 5'd0, 2'd2);
      idle_check(4'hC, 32'h5555_5555);
      idle_check(4'h0, 32'h0000_0001);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [3:0] ro;
         ro = 4'($urandom_range(0, 15));
         run_op(ro, $urandom, 5'($urandom), 2'($urandom));
         if ($urandom_range(0, 9) == 0) idle_check(4'($urandom), $urandom);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule